// File: doc/BRIEF.md
# I/O-Space Bus Target with Four Windows

This block is the slave side of a 32-bit multiplexed address/data bus of the PCI kind, reduced to I/O traffic. It watches for the start of a cycle, latches the address and command, and checks the address against four base registers: a standard window and an extended window for each of two identical ports. On a hit it claims the cycle, runs one or more data phases and inserts wait states until the back-end has answered. It forms each burst address itself, because the initiator never announces how many data phases will follow. It drives even parity one clock behind the data it drives.

Behind the bus sits a plain register strobe. The strobe carries the window index, the byte offset inside the window, the byte enables and the write data. It receives read data and a ready flag in return. Configuration traffic is limited to type-0 configuration writes, which set the four base registers. Tri-state pins are split into value and drive-enable pairs, so the pad ring owns the actual buffers.

Top module: `pci_io_target`

## Requirements
- R1: While reset is held, and after it, until a cycle is claimed, trdy_n and devsel_n are high, and ad_oe, par_oe, ctl_oe and reg_req are low.
- R2: A cycle starts only when frame_n is low in a clock where it was high the clock before, while the target is idle. The command is I/O read (cbe_n = 0010) or I/O write (0011), and its address falls in a programmed window. devsel_n is still high in the clock after the address clock and is low from the second clock on, with ctl_oe high wherever devsel_n is low.
- R3: Any other command, an address outside every window, or a window never written leaves devsel_n high and ctl_oe low for the whole cycle.
- R4: Windows 0 and 2 span 8 bytes and windows 1 and 3 span 4 bytes. Window i's base is set by a configuration write (cbe_n = 1011, idsel high and AD[1:0] = 00 in the address clock) to byte offset 0x10 + 4*i. Only bytes whose enable is active change, address bits inside the window span are stored as zero, and no back-end strobe is issued.
- R5: A data phase completes only on an edge where irdy_n and trdy_n are both low. trdy_n falls in the clock after the edge that sees reg_req and reg_ready together, so with a back-end latency of L clocks, trdy_n falls L+1 clocks after devsel_n.
- R6: An I/O write raises reg_req only while irdy_n is low. reg_wr is 1, reg_wdata is the AD value, and reg_be is the inverted cbe_n.
- R7: An I/O read raises reg_req with reg_wr 0 and drives ad_out with the reg_rdata accepted, from the clock trdy_n falls until the data phase completes. ad_oe is high only while a read is claimed.
- R8: Every completed non-final data phase advances the address by 4, so reg_off steps by 4 modulo the standard window span.
- R9: A completion with frame_n high is the last one. In the next clock trdy_n and devsel_n are high and ctl_oe is low.
- R10: par_out in each clock equals the XOR of ad_out and cbe_n of the clock before, giving even parity over 36 bits, and par_oe equals ad_oe of the clock before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_n | input | 1 | Cycle framing from the initiator, active low |
| irdy_n | input | 1 | Initiator ready, active low |
| idsel | input | 1 | Configuration select |
| cbe_n | input | 4 | Command in the address clock, active-low byte enables after it |
| ad_in | input | 32 | Address/data bus as seen at the pad |
| ad_out | output | 32 | Read data to drive onto the bus |
| ad_oe | output | 1 | Drive enable for ad_out |
| par_out | output | 1 | Even parity for the driven data |
| par_oe | output | 1 | Drive enable for par_out |
| trdy_n | output | 1 | Target ready, active low |
| devsel_n | output | 1 | Claim indication, active low |
| ctl_oe | output | 1 | Drive enable for trdy_n and devsel_n |
| reg_req | output | 1 | Back-end access request |
| reg_wr | output | 1 | 1 for a write access, 0 for a read |
| reg_win | output | 2 | Index of the window hit |
| reg_off | output | 3 | Byte offset inside the window |
| reg_be | output | 4 | Active-high byte enables |
| reg_wdata | output | 32 | Write data |
| reg_rdata | input | 32 | Read data from the back-end |
| reg_ready | input | 1 | Back-end accepts the request this clock |

## Verification
Single reads and writes in each window type show that the index and offset come from the right base, and that byte enables and write data travel unchanged. Three-phase bursts with a slow back-end and two-phase bursts with a fast one separate the address increment from wait-state handling. A read whose irdy_n lags by two clocks shows that trdy_n holds and data stays put while only the initiator stalls. Memory commands, configuration writes without idsel, unwritten windows and an address that falls out of a moved window are the miss patterns that must leave the bus untouched.

// File: rtl/pci_tgt_pkg.sv
// Shared command codes and controller state type for the I/O target.
// Assumes the 4-bit command encoding of the multiplexed bus.
package pci_tgt_pkg;
    localparam logic [3:0] CMD_IO_RD  = 4'b0010;
    localparam logic [3:0] CMD_IO_WR  = 4'b0011;
    localparam logic [3:0] CMD_CFG_WR = 4'b1011;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DECODE,
        ST_ACCESS,
        ST_XFER,
        ST_SKIP
    } tgt_state_e;
endpackage

// File: rtl/pci_tgt_bars.sv
// Base registers for all windows. Even-indexed windows span STD_BYTES and
// odd ones EXT_BYTES; bits below the span are stored as zero. A window
// becomes valid on its first write. Assumes spans are powers of two.
module pci_tgt_bars #(
    parameter int NUM_WIN   = 4,
    parameter int STD_BYTES = 8,
    parameter int EXT_BYTES = 4,
    localparam int WIN_W    = $clog2(NUM_WIN)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [WIN_W-1:0]        wr_idx,
    input  logic [31:0]             wr_data,
    input  logic [3:0]              wr_be,
    output logic [NUM_WIN*32-1:0]   base_flat,
    output logic [NUM_WIN-1:0]      valid
);
    for (genvar i = 0; i < NUM_WIN; i++) begin : g_bar
        localparam int SPAN = (i % 2 == 0) ? STD_BYTES : EXT_BYTES;
        localparam logic [31:0] KEEP = ~(32'(SPAN) - 32'd1);
        logic [31:0] base_q;
        logic [31:0] merged;
        logic        valid_q;

        // Byte-wise merge of the incoming write with the current base.
        always_comb begin
            for (int b = 0; b < 4; b++) begin
                merged[b*8 +: 8] = wr_be[b] ? wr_data[b*8 +: 8] : base_q[b*8 +: 8];
            end
        end

        // Hold the base and its valid flag.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                base_q  <= '0;
                valid_q <= 1'b0;
            end else if (wr_en && wr_idx == WIN_W'(i)) begin
                base_q  <= merged & KEEP;
                valid_q <= 1'b1;
            end
        end

        assign base_flat[i*32 +: 32] = base_q;
        assign valid[i]              = valid_q;
    end
endmodule

// File: rtl/pci_tgt_decode.sv
// Compares an address with every valid window and returns the lowest
// matching index. Purely combinational; assumes bases are already masked.
module pci_tgt_decode #(
    parameter int NUM_WIN   = 4,
    parameter int STD_BYTES = 8,
    parameter int EXT_BYTES = 4,
    localparam int WIN_W    = $clog2(NUM_WIN)
) (
    input  logic [31:0]             addr,
    input  logic [NUM_WIN*32-1:0]   base_flat,
    input  logic [NUM_WIN-1:0]      valid,
    output logic                    hit,
    output logic [WIN_W-1:0]        win
);
    logic [NUM_WIN-1:0] hit_vec;

    for (genvar i = 0; i < NUM_WIN; i++) begin : g_cmp
        localparam int SPAN = (i % 2 == 0) ? STD_BYTES : EXT_BYTES;
        localparam logic [31:0] KEEP = ~(32'(SPAN) - 32'd1);
        assign hit_vec[i] = valid[i] && ((addr & KEEP) == base_flat[i*32 +: 32]);
    end

    // Lowest matching window wins.
    always_comb begin
        hit = 1'b0;
        win = '0;
        for (int i = NUM_WIN - 1; i >= 0; i--) begin
            if (hit_vec[i]) begin
                hit = 1'b1;
                win = WIN_W'(i);
            end
        end
    end
endmodule

// File: rtl/pci_tgt_parity.sv
// Registers even parity over the driven data and the byte enables, and
// delays the data drive enable by one clock to drive the parity line.
module pci_tgt_parity (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [31:0] ad,
    input  logic [3:0]  cbe_n,
    input  logic        drive,
    output logic        par,
    output logic        par_oe
);
    // One-clock-late parity and its drive enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            par    <= 1'b0;
            par_oe <= 1'b0;
        end else begin
            par    <= ^{ad, cbe_n};
            par_oe <= drive;
        end
    end
endmodule

// File: rtl/pci_io_target.sv
// I/O-space target: latches address and command on a FRAME falling edge,
// decodes against the window bases one clock later (medium claim), then
// runs data phases through a register strobe with back-end wait states,
// stepping the address by 4 per phase. Type-0 configuration writes program
// the bases. Assumes the initiator holds AD and IRDY steady once IRDY is low.
module pci_io_target #(
    parameter int NUM_PORTS = 2,
    parameter int STD_BYTES = 8,
    parameter int EXT_BYTES = 4,
    localparam int NUM_WIN  = 2 * NUM_PORTS,
    localparam int WIN_W    = $clog2(NUM_WIN),
    localparam int OFF_W    = $clog2(STD_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_n,
    input  logic              irdy_n,
    input  logic              idsel,
    input  logic [3:0]        cbe_n,
    input  logic [31:0]       ad_in,
    output logic [31:0]       ad_out,
    output logic              ad_oe,
    output logic              par_out,
    output logic              par_oe,
    output logic              trdy_n,
    output logic              devsel_n,
    output logic              ctl_oe,
    output logic              reg_req,
    output logic              reg_wr,
    output logic [WIN_W-1:0]  reg_win,
    output logic [OFF_W-1:0]  reg_off,
    output logic [3:0]        reg_be,
    output logic [31:0]       reg_wdata,
    input  logic [31:0]       reg_rdata,
    input  logic              reg_ready
);
    import pci_tgt_pkg::*;

    localparam logic [5:0] BAR_DW0 = 6'd4;

    tgt_state_e              state;
    logic                    frame_prev;
    logic [31:0]             addr_q;
    logic [3:0]              cmd_q;
    logic                    sel_q;
    logic [WIN_W-1:0]        win_q;
    logic                    devsel_q;
    logic                    trdy_q;
    logic [31:0]             rdata_q;
    logic [NUM_WIN*32-1:0]   base_flat;
    logic [NUM_WIN-1:0]      base_valid;
    logic                    dec_hit;
    logic [WIN_W-1:0]        dec_win;
    logic                    is_io, is_rd, is_cfg, cfg_bar, active, step_ok;
    logic [5:0]              cfg_dw;

    // Command classification of the latched cycle.
    assign is_rd   = (cmd_q == CMD_IO_RD);
    assign is_io   = is_rd || (cmd_q == CMD_IO_WR);
    assign is_cfg  = sel_q && (cmd_q == CMD_CFG_WR) && (addr_q[1:0] == 2'b00);
    assign cfg_dw  = addr_q[7:2];
    assign cfg_bar = (cfg_dw >= BAR_DW0) && (cfg_dw < BAR_DW0 + 6'(NUM_WIN));
    assign active  = (state == ST_ACCESS) || (state == ST_XFER);

    pci_tgt_bars #(
        .NUM_WIN(NUM_WIN), .STD_BYTES(STD_BYTES), .EXT_BYTES(EXT_BYTES)
    ) u_bars (
        .clk(clk), .rst_n(rst_n),
        .wr_en(state == ST_ACCESS && is_cfg && cfg_bar && !irdy_n),
        .wr_idx(WIN_W'(cfg_dw - BAR_DW0)),
        .wr_data(ad_in), .wr_be(~cbe_n),
        .base_flat(base_flat), .valid(base_valid)
    );

    pci_tgt_decode #(
        .NUM_WIN(NUM_WIN), .STD_BYTES(STD_BYTES), .EXT_BYTES(EXT_BYTES)
    ) u_dec (
        .addr(addr_q), .base_flat(base_flat), .valid(base_valid),
        .hit(dec_hit), .win(dec_win)
    );

    pci_tgt_parity u_par (
        .clk(clk), .rst_n(rst_n), .ad(ad_out), .cbe_n(cbe_n),
        .drive(ad_oe), .par(par_out), .par_oe(par_oe)
    );

    // Back-end request: reads at once, writes once the initiator has data.
    assign reg_req = (state == ST_ACCESS) && is_io && (is_rd || !irdy_n);
    // A phase may present TRDY once its data source or sink is ready.
    assign step_ok = is_cfg ? !irdy_n : (reg_req && reg_ready);

    // Cycle sequencer: latch, claim, access, transfer, release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            frame_prev <= 1'b1;
            addr_q     <= '0;
            cmd_q      <= '0;
            sel_q      <= 1'b0;
            win_q      <= '0;
            devsel_q   <= 1'b1;
            trdy_q     <= 1'b1;
            rdata_q    <= '0;
        end else begin
            frame_prev <= frame_n;
            unique case (state)
                ST_IDLE: if (!frame_n && frame_prev) begin
                    addr_q <= ad_in;
                    cmd_q  <= cbe_n;
                    sel_q  <= idsel;
                    state  <= ST_DECODE;
                end
                ST_DECODE: if ((is_io && dec_hit) || is_cfg) begin
                    devsel_q <= 1'b0;
                    win_q    <= dec_win;
                    state    <= ST_ACCESS;
                end else begin
                    state <= ST_SKIP;
                end
                ST_ACCESS: if (step_ok) begin
                    trdy_q <= 1'b0;
                    if (is_rd) rdata_q <= reg_rdata;
                    state <= ST_XFER;
                end
                ST_XFER: if (!irdy_n) begin
                    trdy_q <= 1'b1;
                    if (frame_n) begin
                        devsel_q <= 1'b1;
                        state    <= ST_IDLE;
                    end else begin
                        addr_q <= addr_q + 32'd4;
                        state  <= ST_ACCESS;
                    end
                end
                ST_SKIP: if (frame_n && irdy_n) state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign ad_out    = rdata_q;
    assign ad_oe     = active && is_rd;
    assign trdy_n    = trdy_q;
    assign devsel_n  = devsel_q;
    assign ctl_oe    = active;
    assign reg_wr    = (cmd_q == CMD_IO_WR);
    assign reg_win   = win_q;
    assign reg_off   = addr_q[OFF_W-1:0];
    assign reg_be    = ~cbe_n;
    assign reg_wdata = ad_in;
endmodule

// File: rtl/pci_io_target_chk.sv
// Protocol checker for pci_io_target, attached by bind. Observes ports only.
module pci_io_target_chk #(
    parameter int OFF_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             frame_n,
    input logic             irdy_n,
    input logic             trdy_n,
    input logic             devsel_n,
    input logic             ad_oe,
    input logic             par_oe,
    input logic             ctl_oe,
    input logic             reg_req,
    input logic             reg_ready,
    input logic             reg_wr,
    input logic [OFF_W-1:0] reg_off
);
    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (trdy_n && devsel_n && !ad_oe && !par_oe && !reg_req));

    assert_claim_drives_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !devsel_n |-> ctl_oe);

    assert_trdy_claimed_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !trdy_n |-> !devsel_n);

    assert_trdy_after_ready_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_req && reg_ready) |=> !trdy_n);

    assert_write_needs_irdy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_req && reg_wr) |-> !irdy_n);

    assert_read_drive_claimed_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ad_oe |-> !devsel_n);

    assert_burst_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!trdy_n && !irdy_n && !frame_n) |=> (reg_off == $past(reg_off) + OFF_W'(4)));

    assert_final_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!trdy_n && !irdy_n && frame_n) |=> (trdy_n && devsel_n && !ctl_oe));

    assert_par_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
        par_oe |-> $past(ad_oe));
endmodule

bind pci_io_target pci_io_target_chk #(.OFF_W(OFF_W)) u_chk (.*);

// File: tb/tb_pci_io_target.sv
`timescale 1ns/1ps
module tb_pci_io_target;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_n = 1'b1, irdy_n = 1'b1, idsel = 1'b0;
    logic [3:0]  cbe_n = 4'hF;
    logic [31:0] ad_in = '0;
    logic [31:0] ad_out, reg_wdata, reg_rdata;
    logic        ad_oe, par_out, par_oe, trdy_n, devsel_n, ctl_oe;
    logic        reg_req, reg_wr, reg_ready = 1'b0;
    logic [1:0]  reg_win;
    logic [2:0]  reg_off;
    logic [3:0]  reg_be;

    int tests = 0, fails = 0, be_lat = 0, bcnt = 0;
    bit done = 0;

    typedef struct { int win; int off; logic [3:0] be; logic [31:0] data; } wrec_t;
    wrec_t wq[$];

    pci_io_target dut (.*);

    always #2 clk = ~clk;

    function automatic logic [31:0] rd_pat(int w, int o);
        return 32'hC0DE_0000 | 32'(w << 8) | 32'(o);
    endfunction

    assign reg_rdata = rd_pat(int'(reg_win), int'(reg_off));

    task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Back-end model: answers after be_lat clocks, logs accepted writes.
    always @(negedge clk) begin
        #1;
        if (!rst_n) begin
            reg_ready = 1'b0; bcnt = 0;
        end else if (reg_req && !reg_ready) begin
            if (bcnt >= be_lat) begin
                reg_ready = 1'b1; bcnt = 0;
                if (reg_wr) wq.push_back('{int'(reg_win), int'(reg_off), reg_be, reg_wdata});
            end else begin
                bcnt++;
            end
        end else begin
            reg_ready = 1'b0; bcnt = 0;
        end
    end

    // Per-clock parity reference over the previous clock's bus values (R10).
    logic [31:0] p_ad; logic [3:0] p_cbe; logic p_oe; bit p_ok = 0;
    always @(negedge clk) begin
        #1;
        if (!rst_n) p_ok = 0;
        else begin
            if (p_ok) begin
                chk(par_oe == p_oe, "R10", "par_oe", 32'(par_oe), 32'(p_oe));
                if (par_oe) chk(par_out == ^{p_ad, p_cbe}, "R10", "par_out",
                                32'(par_out), 32'(^{p_ad, p_cbe}));
            end
            p_ad = ad_out; p_cbe = cbe_n; p_oe = ad_oe; p_ok = 1;
        end
    end

    // Initiator: one cycle of nph data phases, irdy delayed by idly clocks.
    task automatic bus_cycle(input logic [3:0] cmd, input logic [31:0] addr, input logic sel,
                             input int nph, input int idly, input logic [3:0] be,
                             input logic [31:0] wbase, input bit claim, input int ewin);
        bit is_wr = (cmd == 4'b0011);
        bit is_rd = (cmd == 4'b0010);
        int p = 0, n = 0, dly = idly, tdev = -1, ttr = -1;
        bit adv = 0;
        @(negedge clk);
        frame_n = 1'b0; ad_in = addr; cbe_n = cmd; idsel = sel; irdy_n = 1'b1;
        @(negedge clk);
        chk(devsel_n == 1'b1, "R2", "devsel one clock after address", 32'(devsel_n), 32'd1);
        cbe_n = ~be; ad_in = is_wr || !is_rd ? wbase : 32'd0; idsel = 1'b0;
        if (idly == 0) begin irdy_n = 1'b0; frame_n = (nph == 1); end
        if (!claim) begin
            bit quiet = 1;
            repeat (4) begin
                @(negedge clk);
                if (!devsel_n || ctl_oe) quiet = 0;
            end
            chk(quiet, "R3", "unclaimed cycle stays quiet", 32'(quiet), 32'd1);
            irdy_n = 1'b1; frame_n = 1'b1;
            @(negedge clk);
            return;
        end
        while (p < nph && n < 100) begin
            @(negedge clk); n++;
            if (adv) begin
                adv = 0; ad_in = wbase + 32'(p); cbe_n = ~be; frame_n = (p == nph - 1);
            end else if (dly > 0) begin
                dly--;
                if (dly == 0) begin irdy_n = 1'b0; frame_n = (nph == 1); end
            end
            if (tdev < 0 && !devsel_n) tdev = n;
            if (ttr < 0 && !trdy_n) ttr = n;
            if (!irdy_n && !trdy_n) begin
                if (is_rd) begin
                    logic [31:0] e = rd_pat(ewin, int'((addr + 32'(4 * p)) & 32'h7));
                    chk(ad_oe == 1'b1, "R7", "ad_oe during read", 32'(ad_oe), 32'd1);
                    chk(ad_out == e, "R7 R8", "read data", ad_out, e);
                end
                p++; adv = 1;
            end
        end
        chk(n < 100, "R5", "all data phases completed", 32'(p), 32'(nph));
        chk(tdev == 1, "R2", "devsel low two clocks after address", 32'(tdev), 32'd1);
        if (idly == 0)
            chk(ttr - tdev == be_lat + 1, "R5", "trdy delay after devsel",
                32'(ttr - tdev), 32'(be_lat + 1));
        @(negedge clk);
        irdy_n = 1'b1;
        chk(trdy_n && devsel_n && !ctl_oe, "R9", "release after final phase",
            {29'd0, trdy_n, devsel_n, ctl_oe}, 32'h6);
        if (is_wr) begin
            chk(wq.size() == nph, "R6", "write strobes", 32'(wq.size()), 32'(nph));
            for (int k = 0; k < nph && wq.size() > 0; k++) begin
                wrec_t r = wq.pop_front();
                int eo = int'((addr + 32'(4 * k)) & 32'h7);
                chk(r.win == ewin, "R6", "write window", 32'(r.win), 32'(ewin));
                chk(r.off == eo, "R8", "write offset", 32'(r.off), 32'(eo));
                chk(r.be == be && r.data == wbase + 32'(k), "R6", "write data",
                    r.data, wbase + 32'(k));
            end
        end else begin
            chk(wq.size() == 0, "R4", "no back-end write", 32'(wq.size()), 32'd0);
        end
    endtask

    task automatic cfg_bar(input int idx, input logic [31:0] data, input logic [3:0] be);
        bus_cycle(4'b1011, 32'h10 + 32'(4 * idx), 1'b1, 1, 0, be, data, 1, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: quiet outputs in reset
        chk(trdy_n && devsel_n && !ad_oe && !par_oe && !ctl_oe && !reg_req, "R1",
            "reset outputs", {26'd0, trdy_n, devsel_n, ad_oe, par_oe, ctl_oe, reg_req}, 32'h30);
        rst_n = 1'b1;
        @(negedge clk);
        chk(trdy_n && devsel_n && !ctl_oe, "R1", "idle after reset",
            {29'd0, trdy_n, devsel_n, ctl_oe}, 32'h6);

        // R3: window never written
        bus_cycle(4'b0010, 32'h0000_0000, 1'b0, 1, 0, 4'hF, 0, 0, 0);

        // R4: program bases; low bits of window 0 dropped
        cfg_bar(0, 32'h0000_1003, 4'hF);
        cfg_bar(1, 32'h0000_1010, 4'hF);
        cfg_bar(2, 32'h0000_2000, 4'hF);
        cfg_bar(3, 32'h0000_200C, 4'hF);
        cfg_bar(2, 32'h0000_3300, 4'b0010);
        // R3: configuration write without idsel
        bus_cycle(4'b1011, 32'h10, 1'b0, 1, 0, 4'hF, 32'h5000, 0, 0);

        be_lat = 0;
        // R2 R7: single read in an extended window
        bus_cycle(4'b0010, 32'h0000_1012, 1'b0, 1, 0, 4'hF, 0, 1, 1);
        // R4: masked base of window 0
        bus_cycle(4'b0010, 32'h0000_1004, 1'b0, 1, 0, 4'hF, 0, 1, 0);
        // R4: window 2 moved by a one-byte write, old base misses
        bus_cycle(4'b0010, 32'h0000_3304, 1'b0, 1, 0, 4'hF, 0, 1, 2);
        bus_cycle(4'b0010, 32'h0000_2000, 1'b0, 1, 0, 4'hF, 0, 0, 0);
        // R6: single write with partial enables
        bus_cycle(4'b0011, 32'h0000_200C, 1'b0, 1, 0, 4'b0101, 32'hA5A5_0000, 1, 3);
        // R3: memory command to a claimed address
        bus_cycle(4'b0110, 32'h0000_1000, 1'b0, 1, 0, 4'hF, 0, 0, 0);

        // R5 R8: burst read with a slow back-end
        be_lat = 2;
        bus_cycle(4'b0010, 32'h0000_1000, 1'b0, 3, 0, 4'hF, 0, 1, 0);
        // R6 R8: burst write with a fast back-end
        be_lat = 0;
        bus_cycle(4'b0011, 32'h0000_3300, 1'b0, 2, 0, 4'hF, 32'h1234_5670, 1, 2);
        // R5: initiator wait states on a read
        bus_cycle(4'b0010, 32'h0000_1004, 1'b0, 1, 2, 4'hF, 0, 1, 0);
        // R5 R8: slow burst write
        be_lat = 1;
        bus_cycle(4'b0011, 32'h0000_1004, 1'b0, 2, 0, 4'b1000, 32'h0BAD_0000, 1, 0);

        repeat (3) @(negedge clk);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule